// File: doc/BRIEF.md
# Three-Channel Linked-Loop DMA Engine

This block is a memory-to-memory copy engine with three channels. Each channel holds its own descriptor. The descriptor gives a source byte address, a destination byte address, a signed step applied to each address after every access, an access-size code, a byte count for one minor loop, a starting iteration count, and signed adjustments that are added to both addresses once the whole major loop is finished. One start pulse makes a channel copy one minor loop. The channel then waits for its next start. When the number of completed minor loops reaches the programmed iteration count, the major loop is complete. At that point the addresses are adjusted, the iteration counter reloads, and a sticky completion flag sets.

Channels can start one another without any software step. A channel can start a chosen target when it finishes a minor loop that is not its last one. It can start another target when it finishes its major loop. A single memory port is shared by all channels, and it is granted by fixed priority. The port is word addressed and moves one beat at a time. Every access is a read beat followed by a write beat, and byte strobes select the lanes that are written.

Top module: `cdma_link_engine`

## Requirements
- R1: One start pulse moves exactly NBYTES bytes (one minor loop). The channel then stays quiet until its next start.
- R2: The iteration counter loads from the programmed count and drops by one for each finished minor loop. DONE stays 0 until the count-th minor loop finishes, and it sets then.
- R3: After every access, the source and destination addresses each move by their own signed step. A negative step walks an address downward.
- R4: Size code 0 moves 1 byte, code 1 moves 2 bytes and code 2 moves 4 bytes. The byte at source lane address[1:0] lands on destination lane address[1:0], and only those strobes are set.
- R5: At major-loop completion, the signed last-adjust values are added to the source and destination addresses. Programming minus the total advance makes the next major loop reuse the same buffers.
- R6: At major-loop completion the iteration counter reloads, so the channel can run a full major loop again without being reprogrammed.
- R7: Link control bit 0 enables the minor link and bits 7:4 select its target. A finished minor loop that is not the final one then starts the target. The final minor loop does not start it.
- R8: Link control bit 1 enables the major link and bits 11:8 select its target. Major-loop completion then starts that target.
- R9: DONE sets on major-loop completion and stays set until clr_done is pulsed. If link control bit 2 is set, IRQ sets as well, and it is cleared only by clr_irq.
- R10: Among pending channels, the lowest-numbered one gets the memory port. A start that arrives while the port is busy is held until it is served.
- R11: A start whose NBYTES is zero or not a multiple of the access width, or whose size code is 3, moves nothing and sets size_err. size_err clears when the channel's descriptor is next written.
- R12: Descriptor writes to a channel that is moving data are ignored. Descriptor writes never clear DONE.
- R13: mem_re and mem_we are never high together. Every read beat is followed in the next cycle by its write beat, and both are low out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_ch | input | CHW | Channel index of the descriptor write |
| cfg_sel | input | 4 | Field select: 0 src, 1 dst, 2 src step, 3 dst step, 4 size, 5 nbytes, 6 count, 7 src adjust, 8 dst adjust, 9 link control |
| cfg_wdata | input | 32 | Descriptor write data |
| start | input | NCH | Software start, one bit per channel |
| clr_done | input | NCH | Clear DONE, one bit per channel |
| clr_irq | input | NCH | Clear IRQ, one bit per channel |
| mem_re | output | 1 | Read beat; data is returned on mem_rdata in the next cycle |
| mem_we | output | 1 | Write beat |
| mem_addr | output | AW-2 | Word address |
| mem_wdata | output | 32 | Write data, lane aligned |
| mem_wstrb | output | 4 | Byte write strobes |
| mem_rdata | input | 32 | Read data |
| done | output | NCH | Sticky major-loop completion flags |
| irq | output | NCH | Sticky interrupt flags |
| size_err | output | NCH | Rejected-start flags |

## Verification
The bench targets the boundaries of the loop counters. It checks memory after each single start, so a design that ran the whole major loop on one start, or that set DONE one minor loop early, leaves wrong bytes or a wrong flag. A second pass with fresh source data catches a design that skips the end-of-major adjustment or forgets to reload the iteration counter, because that design writes past the original buffers. Chaining tests check that the final minor loop does not fire its minor link, and that simultaneous or overlapping starts finish in priority order. A design that queued them wrongly would show DONE in the wrong order. A start with a bad byte count, and a descriptor write during a transfer, must leave memory exactly as it was.

// File: rtl/cdma_pkg.sv
package cdma_pkg;

  localparam logic [3:0] F_SRC    = 4'd0;
  localparam logic [3:0] F_DST    = 4'd1;
  localparam logic [3:0] F_SSTEP  = 4'd2;
  localparam logic [3:0] F_DSTEP  = 4'd3;
  localparam logic [3:0] F_SIZE   = 4'd4;
  localparam logic [3:0] F_NBYTES = 4'd5;
  localparam logic [3:0] F_COUNT  = 4'd6;
  localparam logic [3:0] F_SADJ   = 4'd7;
  localparam logic [3:0] F_DADJ   = 4'd8;
  localparam logic [3:0] F_LINK   = 4'd9;

  typedef enum logic [1:0] {
    MV_IDLE = 2'd0,
    MV_RD   = 2'd1,
    MV_WR   = 2'd2
  } mv_state_e;

  typedef struct packed {
    logic [3:0] major_tgt;
    logic [3:0] minor_tgt;
    logic       int_en;
    logic       major_en;
    logic       minor_en;
  } link_t;

  function automatic logic [2:0] size_bytes(input logic [1:0] code);
    case (code)
      2'd0:    size_bytes = 3'd1;
      2'd1:    size_bytes = 3'd2;
      2'd2:    size_bytes = 3'd4;
      default: size_bytes = 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/cdma_desc_bank.sv
module cdma_desc_bank
  import cdma_pkg::*;
#(
  parameter int NCH = 3,
  parameter int AW  = 10,
  parameter int NBW = 16,
  parameter int ITW = 8,
  parameter int CHW = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CHW-1:0]   cfg_ch,
  input  logic [3:0]       cfg_sel,
  input  logic [31:0]      cfg_wdata,
  input  logic             act,
  input  logic [CHW-1:0]   act_ch,
  input  logic             upd,
  input  logic [AW-1:0]    new_src,
  input  logic [AW-1:0]    new_dst,
  input  logic [ITW-1:0]   new_citer,
  input  logic             major_end,
  input  logic             err_pulse,
  input  logic [CHW-1:0]   err_ch,
  input  logic [NCH-1:0]   clr_done,
  input  logic [NCH-1:0]   clr_irq,
  output logic [AW-1:0]    src_o    [NCH],
  output logic [AW-1:0]    dst_o    [NCH],
  output logic [AW-1:0]    sstep_o  [NCH],
  output logic [AW-1:0]    dstep_o  [NCH],
  output logic [1:0]       size_o   [NCH],
  output logic [NBW-1:0]   nbytes_o [NCH],
  output logic [ITW-1:0]   biter_o  [NCH],
  output logic [ITW-1:0]   citer_o  [NCH],
  output logic [AW-1:0]    sadj_o   [NCH],
  output logic [AW-1:0]    dadj_o   [NCH],
  output link_t            link_o   [NCH],
  output logic [NCH-1:0]   done_o,
  output logic [NCH-1:0]   irq_o,
  output logic [NCH-1:0]   err_o
);

  logic unused_wdata;
  assign unused_wdata = ^{cfg_wdata[31:12], cfg_wdata[3]};

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [AW-1:0]  src_q, src_n, dst_q, dst_n;
    logic [AW-1:0]  sstep_q, sstep_n, dstep_q, dstep_n;
    logic [AW-1:0]  sadj_q, sadj_n, dadj_q, dadj_n;
    logic [1:0]     size_q, size_n;
    logic [NBW-1:0] nb_q, nb_n;
    logic [ITW-1:0] biter_q, biter_n, citer_q, citer_n;
    link_t          link_q, link_n;
    logic           done_q, done_n, irq_q, irq_n, err_q, err_n;
    logic           busy_me, wr_ok, upd_me;

    assign busy_me = act && (act_ch == CHW'(g));
    assign wr_ok   = cfg_we && (cfg_ch == CHW'(g)) && !busy_me;
    assign upd_me  = upd && (act_ch == CHW'(g));

    always_comb begin
      src_n   = src_q;
      dst_n   = dst_q;
      sstep_n = sstep_q;
      dstep_n = dstep_q;
      sadj_n  = sadj_q;
      dadj_n  = dadj_q;
      size_n  = size_q;
      nb_n    = nb_q;
      biter_n = biter_q;
      citer_n = citer_q;
      link_n  = link_q;
      if (wr_ok) begin
        case (cfg_sel)
          F_SRC:    src_n   = cfg_wdata[AW-1:0];
          F_DST:    dst_n   = cfg_wdata[AW-1:0];
          F_SSTEP:  sstep_n = cfg_wdata[AW-1:0];
          F_DSTEP:  dstep_n = cfg_wdata[AW-1:0];
          F_SIZE:   size_n  = cfg_wdata[1:0];
          F_NBYTES: nb_n    = cfg_wdata[NBW-1:0];
          F_COUNT: begin
            biter_n = cfg_wdata[ITW-1:0];
            citer_n = cfg_wdata[ITW-1:0];
          end
          F_SADJ:   sadj_n  = cfg_wdata[AW-1:0];
          F_DADJ:   dadj_n  = cfg_wdata[AW-1:0];
          F_LINK: begin
            link_n.minor_en  = cfg_wdata[0];
            link_n.major_en  = cfg_wdata[1];
            link_n.int_en    = cfg_wdata[2];
            link_n.minor_tgt = cfg_wdata[7:4];
            link_n.major_tgt = cfg_wdata[11:8];
          end
          default: ;
        endcase
      end
      if (upd_me) begin
        src_n   = new_src;
        dst_n   = new_dst;
        citer_n = new_citer;
      end
    end

    always_comb begin
      done_n = (done_q && !clr_done[g]) || (major_end && upd_me);
      irq_n  = (irq_q && !clr_irq[g]) || (major_end && upd_me && link_q.int_en);
      if (err_pulse && (err_ch == CHW'(g))) begin
        err_n = 1'b1;
      end else if (wr_ok) begin
        err_n = 1'b0;
      end else begin
        err_n = err_q;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        src_q   <= '0;
        dst_q   <= '0;
        sstep_q <= '0;
        dstep_q <= '0;
        sadj_q  <= '0;
        dadj_q  <= '0;
        size_q  <= '0;
        nb_q    <= '0;
        biter_q <= '0;
        citer_q <= '0;
        link_q  <= '0;
        done_q  <= 1'b0;
        irq_q   <= 1'b0;
        err_q   <= 1'b0;
      end else begin
        src_q   <= src_n;
        dst_q   <= dst_n;
        sstep_q <= sstep_n;
        dstep_q <= dstep_n;
        sadj_q  <= sadj_n;
        dadj_q  <= dadj_n;
        size_q  <= size_n;
        nb_q    <= nb_n;
        biter_q <= biter_n;
        citer_q <= citer_n;
        link_q  <= link_n;
        done_q  <= done_n;
        irq_q   <= irq_n;
        err_q   <= err_n;
      end
    end

    assign src_o[g]    = src_q;
    assign dst_o[g]    = dst_q;
    assign sstep_o[g]  = sstep_q;
    assign dstep_o[g]  = dstep_q;
    assign sadj_o[g]   = sadj_q;
    assign dadj_o[g]   = dadj_q;
    assign size_o[g]   = size_q;
    assign nbytes_o[g] = nb_q;
    assign biter_o[g]  = biter_q;
    assign citer_o[g]  = citer_q;
    assign link_o[g]   = link_q;
    assign done_o[g]   = done_q;
    assign irq_o[g]    = irq_q;
    assign err_o[g]    = err_q;
  end

endmodule

// File: rtl/cdma_arb.sv
module cdma_arb #(
  parameter int NCH = 3,
  parameter int CHW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] req,
  input  logic           take,
  output logic           pend_any,
  output logic [CHW-1:0] pick
);

  logic [NCH-1:0] pend_q, pend_n, taken;

  always_comb begin
    pick = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (pend_q[i]) pick = CHW'(i);
    end
  end

  assign pend_any = |pend_q;

  always_comb begin
    taken = '0;
    if (take) taken[pick] = 1'b1;
    pend_n = (pend_q & ~taken) | req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else begin
      pend_q <= pend_n;
    end
  end

endmodule

// File: rtl/cdma_mover.sv
module cdma_mover
  import cdma_pkg::*;
#(
  parameter int NCH = 3,
  parameter int AW  = 10,
  parameter int NBW = 16,
  parameter int ITW = 8,
  parameter int CHW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pend_any,
  input  logic [CHW-1:0] pick,
  input  logic [AW-1:0]  src_i    [NCH],
  input  logic [AW-1:0]  dst_i    [NCH],
  input  logic [AW-1:0]  sstep_i  [NCH],
  input  logic [AW-1:0]  dstep_i  [NCH],
  input  logic [1:0]     size_i   [NCH],
  input  logic [NBW-1:0] nbytes_i [NCH],
  input  logic [ITW-1:0] biter_i  [NCH],
  input  logic [ITW-1:0] citer_i  [NCH],
  input  logic [AW-1:0]  sadj_i   [NCH],
  input  logic [AW-1:0]  dadj_i   [NCH],
  input  logic [31:0]    mem_rdata,
  output logic           take,
  output logic           act,
  output logic [CHW-1:0] act_ch,
  output logic           upd,
  output logic [AW-1:0]  new_src,
  output logic [AW-1:0]  new_dst,
  output logic [ITW-1:0] new_citer,
  output logic           minor_end,
  output logic           major_end,
  output logic           err_pulse,
  output logic           mem_re,
  output logic           mem_we,
  output logic [AW-3:0]  mem_addr,
  output logic [31:0]    mem_wdata,
  output logic [3:0]     mem_wstrb
);

  mv_state_e      state_q, state_n;
  logic [CHW-1:0] ch_q, ch_n;
  logic [NBW-1:0] rem_q, rem_n;
  logic [NBW-1:0] wid_act, wid_pick;
  logic           bad_pick;
  logic [3:0]     lane_mask;
  logic [31:0]    rd_shift;

  assign wid_act  = NBW'(size_bytes(size_i[ch_q]));
  assign wid_pick = NBW'(size_bytes(size_i[pick]));
  assign bad_pick = (size_i[pick] == 2'd3) || (nbytes_i[pick] == '0) ||
                    ((nbytes_i[pick] & (wid_pick - NBW'(1))) != '0) ||
                    (citer_i[pick] == '0);

  always_comb begin
    case (size_i[ch_q])
      2'd0:    lane_mask = 4'b0001;
      2'd1:    lane_mask = 4'b0011;
      default: lane_mask = 4'b1111;
    endcase
  end

  assign rd_shift = mem_rdata >> {src_i[ch_q][1:0], 3'b000};
  assign act      = (state_q != MV_IDLE);
  assign act_ch   = ch_q;

  always_comb begin
    state_n   = state_q;
    ch_n      = ch_q;
    rem_n     = rem_q;
    take      = 1'b0;
    err_pulse = 1'b0;
    upd       = 1'b0;
    minor_end = 1'b0;
    major_end = 1'b0;
    new_src   = src_i[ch_q];
    new_dst   = dst_i[ch_q];
    new_citer = citer_i[ch_q];
    mem_re    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    mem_wstrb = '0;
    case (state_q)
      MV_IDLE: begin
        if (pend_any) begin
          take = 1'b1;
          if (bad_pick) begin
            err_pulse = 1'b1;
          end else begin
            ch_n    = pick;
            rem_n   = nbytes_i[pick];
            state_n = MV_RD;
          end
        end
      end
      MV_RD: begin
        mem_re   = 1'b1;
        mem_addr = src_i[ch_q][AW-1:2];
        state_n  = MV_WR;
      end
      MV_WR: begin
        mem_we    = 1'b1;
        mem_addr  = dst_i[ch_q][AW-1:2];
        mem_wdata = rd_shift << {dst_i[ch_q][1:0], 3'b000};
        mem_wstrb = lane_mask << dst_i[ch_q][1:0];
        upd       = 1'b1;
        new_src   = src_i[ch_q] + sstep_i[ch_q];
        new_dst   = dst_i[ch_q] + dstep_i[ch_q];
        rem_n     = rem_q - wid_act;
        if (rem_q == wid_act) begin
          minor_end = 1'b1;
          state_n   = MV_IDLE;
          if (citer_i[ch_q] == ITW'(1)) begin
            major_end = 1'b1;
            new_src   = src_i[ch_q] + sstep_i[ch_q] + sadj_i[ch_q];
            new_dst   = dst_i[ch_q] + dstep_i[ch_q] + dadj_i[ch_q];
            new_citer = biter_i[ch_q];
          end else begin
            new_citer = citer_i[ch_q] - ITW'(1);
          end
        end else begin
          state_n = MV_RD;
        end
      end
      default: state_n = MV_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= MV_IDLE;
      ch_q    <= '0;
      rem_q   <= '0;
    end else begin
      state_q <= state_n;
      ch_q    <= ch_n;
      rem_q   <= rem_n;
    end
  end

endmodule

// File: rtl/cdma_link_engine.sv
module cdma_link_engine
  import cdma_pkg::*;
#(
  parameter int NCH = 3,
  parameter int AW  = 10,
  parameter int NBW = 16,
  parameter int ITW = 8,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [CHW-1:0] cfg_ch,
  input  logic [3:0]     cfg_sel,
  input  logic [31:0]    cfg_wdata,
  input  logic [NCH-1:0] start,
  input  logic [NCH-1:0] clr_done,
  input  logic [NCH-1:0] clr_irq,
  output logic           mem_re,
  output logic           mem_we,
  output logic [AW-3:0]  mem_addr,
  output logic [31:0]    mem_wdata,
  output logic [3:0]     mem_wstrb,
  input  logic [31:0]    mem_rdata,
  output logic [NCH-1:0] done,
  output logic [NCH-1:0] irq,
  output logic [NCH-1:0] size_err
);

  logic [AW-1:0]  src    [NCH];
  logic [AW-1:0]  dst    [NCH];
  logic [AW-1:0]  sstep  [NCH];
  logic [AW-1:0]  dstep  [NCH];
  logic [1:0]     size   [NCH];
  logic [NBW-1:0] nbytes [NCH];
  logic [ITW-1:0] biter  [NCH];
  logic [ITW-1:0] citer  [NCH];
  logic [AW-1:0]  sadj   [NCH];
  logic [AW-1:0]  dadj   [NCH];
  link_t          link   [NCH];

  logic           pend_any, take, act, upd, minor_end, major_end, err_pulse;
  logic [CHW-1:0] pick, act_ch;
  logic [AW-1:0]  new_src, new_dst;
  logic [ITW-1:0] new_citer;
  logic [NCH-1:0] link_req, req;

  always_comb begin
    link_req = '0;
    for (int i = 0; i < NCH; i++) begin
      if (minor_end && !major_end && link[act_ch].minor_en &&
          (link[act_ch].minor_tgt == 4'(i))) begin
        link_req[i] = 1'b1;
      end
      if (major_end && link[act_ch].major_en &&
          (link[act_ch].major_tgt == 4'(i))) begin
        link_req[i] = 1'b1;
      end
    end
  end

  assign req = start | link_req;

  cdma_desc_bank #(
    .NCH(NCH), .AW(AW), .NBW(NBW), .ITW(ITW), .CHW(CHW)
  ) u_bank (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .act(act), .act_ch(act_ch), .upd(upd),
    .new_src(new_src), .new_dst(new_dst), .new_citer(new_citer),
    .major_end(major_end), .err_pulse(err_pulse), .err_ch(pick),
    .clr_done(clr_done), .clr_irq(clr_irq),
    .src_o(src), .dst_o(dst), .sstep_o(sstep), .dstep_o(dstep),
    .size_o(size), .nbytes_o(nbytes), .biter_o(biter), .citer_o(citer),
    .sadj_o(sadj), .dadj_o(dadj), .link_o(link),
    .done_o(done), .irq_o(irq), .err_o(size_err)
  );

  cdma_arb #(.NCH(NCH), .CHW(CHW)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(req), .take(take),
    .pend_any(pend_any), .pick(pick)
  );

  cdma_mover #(
    .NCH(NCH), .AW(AW), .NBW(NBW), .ITW(ITW), .CHW(CHW)
  ) u_mover (
    .clk(clk), .rst_n(rst_n), .pend_any(pend_any), .pick(pick),
    .src_i(src), .dst_i(dst), .sstep_i(sstep), .dstep_i(dstep),
    .size_i(size), .nbytes_i(nbytes), .biter_i(biter), .citer_i(citer),
    .sadj_i(sadj), .dadj_i(dadj), .mem_rdata(mem_rdata),
    .take(take), .act(act), .act_ch(act_ch), .upd(upd),
    .new_src(new_src), .new_dst(new_dst), .new_citer(new_citer),
    .minor_end(minor_end), .major_end(major_end), .err_pulse(err_pulse),
    .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_wstrb(mem_wstrb)
  );

endmodule

// File: rtl/cdma_link_engine_chk.sv
module cdma_link_engine_chk #(
  parameter int NCH = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           mem_re,
  input logic           mem_we,
  input logic [3:0]     mem_wstrb,
  input logic [NCH-1:0] done,
  input logic [NCH-1:0] irq,
  input logic [NCH-1:0] clr_done
);

  p_rw_excl_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_re && mem_we));

  p_rd_then_wr_r13: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> mem_we);

  p_wr_has_rd_r13: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(mem_re));

  p_strobe_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (($countones(mem_wstrb) == 1) || ($countones(mem_wstrb) == 2) ||
                ($countones(mem_wstrb) == 4)));

  for (genvar g = 0; g < NCH; g++) begin : g_flag
    p_done_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (done[g] && !clr_done[g]) |=> done[g]);

    p_irq_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq[g]) |-> done[g]);
  end

endmodule

bind cdma_link_engine cdma_link_engine_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_re(mem_re), .mem_we(mem_we),
  .mem_wstrb(mem_wstrb), .done(done), .irq(irq), .clr_done(clr_done)
);

// File: tb/sim_cdma_link_engine.sv
module sim_cdma_link_engine;
  import cdma_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int NCH  = 3;
  localparam int AW   = 10;
  localparam int MEMB = 1 << AW;

  typedef struct packed {
    logic [1:0]  ch;
    logic [1:0]  sz;
    logic [9:0]  src;
    logic [9:0]  dst;
    logic [15:0] sstep;
    logic [15:0] dstep;
    logic [15:0] nb;
    logic [7:0]  bi;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{2'd0, 2'd2, 10'h000, 10'h100, 16'd4,      16'd4, 16'd8,  8'd2},
    '{2'd1, 2'd0, 10'h021, 10'h143, 16'd1,      16'd1, 16'd5,  8'd3},
    '{2'd2, 2'd1, 10'h042, 10'h182, 16'd2,      16'd2, 16'd6,  8'd1},
    '{2'd0, 2'd2, 10'h05C, 10'h1C0, 16'hFFFC,   16'd4, 16'd16, 8'd1},
    '{2'd1, 2'd1, 10'h060, 10'h1E0, 16'd2,      16'd4, 16'd4,  8'd2}
  };

  logic           clk, rst_n;
  logic           cfg_we;
  logic [1:0]     cfg_ch;
  logic [3:0]     cfg_sel;
  logic [31:0]    cfg_wdata;
  logic [NCH-1:0] start, clr_done, clr_irq;
  logic           mem_re, mem_we;
  logic [AW-3:0]  mem_addr;
  logic [31:0]    mem_wdata, mem_rdata, rq;
  logic [3:0]     mem_wstrb;
  logic [NCH-1:0] done, irq, size_err;

  logic [7:0] mem   [MEMB];
  logic [7:0] exp_m [MEMB];
  int nchk, nfail, cyc;
  int t_done [NCH];
  logic [NCH-1:0] dprev;
  bit finished;

  cdma_link_engine #(.NCH(NCH), .AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .start(start),
    .clr_done(clr_done), .clr_irq(clr_irq), .mem_re(mem_re), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_wstrb(mem_wstrb),
    .mem_rdata(mem_rdata), .done(done), .irq(irq), .size_err(size_err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_re) rq <= {mem[{mem_addr, 2'd3}], mem[{mem_addr, 2'd2}],
                       mem[{mem_addr, 2'd1}], mem[{mem_addr, 2'd0}]};
    if (mem_we) begin
      for (int b = 0; b < 4; b++) begin
        if (mem_wstrb[b]) mem[{mem_addr, 2'(b)}] <= mem_wdata[8*b +: 8];
      end
    end
  end
  assign mem_rdata = rq;

  always @(negedge clk) begin
    for (int i = 0; i < NCH; i++) begin
      if (done[i] && !dprev[i]) t_done[i] = cyc;
    end
    dprev <= done;
  end

  task automatic chk(input string tag, input int act, input int expv);
    nchk++;
    if (act != expv) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(input int ch, input logic [3:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ch = 2'(ch); cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic kick(input logic [NCH-1:0] m);
    @(negedge clk); start = m;
    @(negedge clk); start = '0;
  endtask

  task automatic clear(input logic [NCH-1:0] d, input logic [NCH-1:0] q);
    @(negedge clk); clr_done = d; clr_irq = q;
    @(negedge clk); clr_done = '0; clr_irq = '0;
  endtask

  task automatic fill(input int seed);
    for (int a = 0; a < 256; a++) begin
      mem[a]   = 8'(a * 13 + seed);
      exp_m[a] = 8'(a * 13 + seed);
    end
  endtask

  task automatic model(input int s0, input int d0, input int ss, input int ds,
                       input int w, input int from, input int upto);
    for (int j = from; j < upto; j++) begin
      for (int b = 0; b < w; b++) begin
        exp_m[(d0 + j * ds + b) & (MEMB - 1)] = exp_m[(s0 + j * ss + b) & (MEMB - 1)];
      end
    end
  endtask

  task automatic cmp_mem(input string tag);
    int bad;
    bad = 0;
    for (int a = 0; a < MEMB; a++) if (mem[a] !== exp_m[a]) bad++;
    chk(tag, bad, 0);
  endtask

  task automatic setup(input int ch, input int sz, input int s, input int d,
                       input int ss, input int ds, input int nb, input int bi,
                       input logic [31:0] lnk);
    int nacc;
    nacc = nb / (1 << sz);
    cfg(ch, F_SRC, 32'(s));
    cfg(ch, F_DST, 32'(d));
    cfg(ch, F_SSTEP, 32'(ss));
    cfg(ch, F_DSTEP, 32'(ds));
    cfg(ch, F_SIZE, 32'(sz));
    cfg(ch, F_NBYTES, 32'(nb));
    cfg(ch, F_COUNT, 32'(bi));
    cfg(ch, F_SADJ, 32'(-(ss * nacc * bi)));
    cfg(ch, F_DADJ, 32'(-(ds * nacc * bi)));
    cfg(ch, F_LINK, lnk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nchk++; nfail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    nchk = 0; nfail = 0; cyc = 0; finished = 1'b0; dprev = '0;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_ch = '0; cfg_sel = '0; cfg_wdata = '0;
    start = '0; clr_done = '0; clr_irq = '0;
    for (int a = 0; a < MEMB; a++) begin mem[a] = 8'h00; exp_m[a] = 8'h00; end
    for (int i = 0; i < NCH; i++) t_done[i] = 0;
    idle(3);
    chk("R13 reset rd/wr", int'({mem_re, mem_we}), 0);
    chk("R9 reset flags", int'({done, irq}), 0);
    chk("R11 reset size_err", int'(size_err), 0);
    @(negedge clk) rst_n = 1'b1;
    idle(2);

    // R1 R2 R3 R4 R5 R6: vector table walk
    for (int i = 0; i < 5; i++) begin
      vec_t v;
      int w, nacc, ss, ds;
      v = VECS[i];
      w = 1 << v.sz;
      nacc = int'(v.nb) / w;
      ss = int'($signed(v.sstep));
      ds = int'($signed(v.dstep));
      fill(i * 5 + 1);
      setup(v.ch, v.sz, v.src, v.dst, ss, ds, v.nb, v.bi, 32'h0);
      for (int t = 0; t < int'(v.bi); t++) begin
        kick(3'b001 << v.ch);
        idle(60);
        model(v.src, v.dst, ss, ds, w, t * nacc, (t + 1) * nacc);
        cmp_mem("R1 one minor per start");
        if (t < int'(v.bi) - 1) chk("R2 done early", int'(done[v.ch]), 0);
      end
      chk("R2 done at count", int'(done[v.ch]), 1);
      chk("R9 no irq when disabled", int'(irq[v.ch]), 0);
      cmp_mem("R3/R4 steps and lanes");
      clear(3'b001 << v.ch, '0);
      fill(i * 5 + 77);
      for (int t = 0; t < int'(v.bi); t++) begin
        kick(3'b001 << v.ch);
        idle(60);
      end
      model(v.src, v.dst, ss, ds, w, 0, nacc * int'(v.bi));
      cmp_mem("R5 rewound buffers reused");
      chk("R6 reloaded count completes", int'(done[v.ch]), 1);
      clear(3'b001 << v.ch, '0);
    end

    // R7 R8 R9: chaining
    fill(9);
    setup(0, 2, 12'h000, 12'h200, 4, 4, 8, 2, 32'h0000_0213);
    setup(1, 2, 12'h000, 12'h240, 4, 4, 16, 1, 32'h0);
    setup(2, 2, 12'h000, 12'h280, 4, 4, 16, 1, 32'h0000_0004);
    kick(3'b001);
    idle(80);
    model(0, 12'h200, 4, 4, 4, 0, 2);
    model(0, 12'h240, 4, 4, 4, 0, 4);
    cmp_mem("R7 minor link copy");
    chk("R7 minor link done", int'(done), 3'b010);
    clear(3'b010, '0);
    kick(3'b001);
    idle(80);
    model(0, 12'h200, 4, 4, 4, 2, 4);
    model(0, 12'h280, 4, 4, 4, 0, 4);
    cmp_mem("R8 major link copy");
    chk("R8 major link done", int'(done), 3'b101);
    chk("R7 final minor no link", int'(done[1]), 0);
    chk("R9 irq only where enabled", int'(irq), 3'b100);
    clear('0, 3'b100);
    chk("R9 irq cleared alone", int'({irq[2], done[2]}), 2'b01);
    clear(3'b111, '0);
    chk("R9 done cleared", int'(done), 0);

    // R10: priority and held requests
    setup(0, 0, 12'h000, 12'h300, 1, 1, 8, 1, 32'h0);
    setup(1, 0, 12'h000, 12'h310, 1, 1, 8, 1, 32'h0);
    setup(2, 0, 12'h000, 12'h320, 1, 1, 8, 1, 32'h0);
    kick(3'b111);
    idle(80);
    chk("R10 ch0 before ch1", int'(t_done[0] < t_done[1]), 1);
    chk("R10 ch1 before ch2", int'(t_done[1] < t_done[2]), 1);
    clear(3'b111, '0);
    kick(3'b100);
    kick(3'b011);
    idle(80);
    chk("R10 held behind busy ch2", int'(t_done[2] < t_done[0]), 1);
    chk("R10 ch0 before ch1 when held", int'(t_done[0] < t_done[1]), 1);
    model(0, 12'h300, 1, 1, 1, 0, 8);
    model(0, 12'h310, 1, 1, 1, 0, 8);
    model(0, 12'h320, 1, 1, 1, 0, 8);
    cmp_mem("R10 all copies");
    clear(3'b111, '0);

    // R11: bad byte count
    setup(1, 2, 12'h000, 12'h340, 4, 4, 6, 1, 32'h0);
    kick(3'b010);
    idle(20);
    chk("R11 size_err set", int'(size_err[1]), 1);
    chk("R11 not started", int'(done[1]), 0);
    cmp_mem("R11 memory untouched");
    cfg(1, F_NBYTES, 32'd8);
    chk("R11 size_err cleared by write", int'(size_err[1]), 0);

    // R12: writes while busy are ignored, never clear done
    setup(0, 0, 12'h000, 12'h380, 1, 1, 16, 1, 32'h0);
    kick(3'b001);
    idle(4);
    cfg(0, F_DST, 32'h3C0);
    idle(60);
    model(0, 12'h380, 1, 1, 1, 0, 16);
    cmp_mem("R12 busy write ignored");
    chk("R12 done after run", int'(done[0]), 1);
    cfg(0, F_SSTEP, 32'd1);
    chk("R12 write keeps done", int'(done[0]), 1);

    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

endmodule